// File: doc/BRIEF.md
# Primary Interrupt Pending Controller

This block collects 32 raw interrupt sources into a two-stage pending structure. Any source seen high on a clock edge sets a sticky bit in the source-pending register. A mask register then gates which pending sources may compete. A fixed-priority arbiter moves the single winning source into a one-hot interrupt-pending register, but only while that register is empty. The single interrupt line follows that register, and an index register holds the position of the active source so the handler can find it quickly. Software clears both pending stages by writing ones.

To acknowledge a level-type source without an immediate re-trigger, software masks it first, then clears its source-pending bit, then clears its interrupt-pending bit. Two of the inputs, index 4 and index 5, carry OR-summaries from an external-pin controller (pins 4–7 and pins 8–23). The core treats them exactly like any other source. A separate wake mask chooses which pending sources may raise a wake request during sleep. Only sources in a parameterised allow set can have their wake bit opened.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the mask and wake-mask registers read all ones, source-pending and interrupt-pending read zero, and irq_o, wake_o and offset_o are 0.
- R2: A source input that is high on a clock edge sets its source-pending bit, which stays set until cleared. Writing a 0 bit to source-pending leaves that bit unchanged.
- R3: Writing a 1 to a bit of source-pending (address 0) or interrupt-pending (address 2) clears that bit on the write edge. If a source is high on the same edge its source-pending clear is ignored, and the bit stays set.
- R4: A source whose mask bit (address 1) is 1 never enters interrupt-pending. A 0 mask bit lets it compete.
- R5: When several unmasked sources are pending, the lowest index wins. Interrupt-pending never has more than one bit set.
- R6: Interrupt-pending loads only on an edge where it is empty. A loaded bit is held, even when lower-index sources arrive, until software clears it. The next winner then loads on the following edge.
- R7: irq_o is high exactly when interrupt-pending is nonzero. offset_o, which is also readable at address 3, gives the index of the last loaded bit and holds it while interrupt-pending is empty.
- R8: The wake mask (address 4) resets to all ones. A written 0 takes effect only on bits in the allow set, which by default is sources 0–3 and 30. Every other bit stays 1 whatever is written.
- R9: wake_o is high when any source-pending bit is set whose wake-mask bit is 0. The interrupt mask has no effect on wake_o.
- R10: The grouped-summary inputs at indices 4 and 5 latch, mask and arbitrate exactly like single sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt sources, bit n is source n |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address: 0 src-pend, 1 mask, 2 int-pend, 3 offset, 4 wake mask |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Interrupt request |
| offset_o | output | 5 | Index of the active interrupt-pending bit |
| wake_o | output | 1 | Wake request |

## Verification
The bench goes after the priority edges: index 0 against index 31, several sources arriving on the same edge, and masked low-index sources that must lose to a higher unmasked one. A wrong priority encoder would report the wrong offset. A design that reloads interrupt-pending while it is still occupied would let a later lower-index source overwrite the one being serviced. This is checked by holding an active source while a better one arrives, then confirming that the better one loads only after the clear. Set-versus-clear collisions are also covered, along with zero writes to the clear-on-one registers, since a design that gets these wrong would lose or invent pending state. The tests also try to open disallowed wake bits, and check that wake_o ignores the interrupt mask.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SRC  = 3'd0,
    REG_MASK = 3'd1,
    REG_INT  = 3'd2,
    REG_OFF  = 3'd3,
    REG_WAKE = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_src_pend.sv
module irq_src_pend #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q[g] <= 1'b0;
      else if (src_i[g])  pend_q[g] <= 1'b1;   // set beats clear
      else if (clr_i[g])  pend_q[g] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0)); // R2
  AST_SRC_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(src_i) & ~pend_q) == '0)); // R3
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N     = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     clr_i,
  output logic [N-1:0]     int_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0]     req;
  logic             any_req;
  logic [IDX_W-1:0] pick;
  logic [N-1:0]     int_q;
  logic [IDX_W-1:0] idx_q;

  assign req     = pend_i & ~mask_i;
  assign any_req = |req;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) pick = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= '0;
      idx_q <= '0;
    end else if (int_q == '0) begin
      if (any_req) begin
        int_q <= N'(1) << pick;
        idx_q <= pick;
      end
    end else begin
      int_q <= int_q & ~clr_i;
    end
  end

  assign int_o = int_q;
  assign idx_o = idx_q;

  AST_INT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(int_q)); // R5
  AST_MASKED_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_q == '0) |=> ((int_q & ~$past(pend_i & ~mask_i)) == '0)); // R4
  AST_HOLD_UNTIL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int_q != '0) && ((int_q & clr_i) == '0)) |=> $stable(int_q)); // R6
  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int_q == '0) && any_req) |=> (int_q != '0)); // R6
  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_q != '0) |-> int_q[idx_q]); // R7
endmodule

// File: rtl/irq_wake.sv
module irq_wake #(
  parameter int unsigned  N     = 32,
  parameter logic [N-1:0] ALLOW = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] wmask_o,
  output logic         wake_o
);
  logic [N-1:0] wmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wmask_q <= '1;
    else if (we_i) wmask_q <= wdata_i | ~ALLOW;  // disallowed bits stay closed
  end

  assign wmask_o = wmask_q;
  assign wake_o  = |(pend_i & ~wmask_q);

  AST_WAKE_ALLOWED_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wmask_q | ALLOW) == '1)); // R8
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int unsigned  N          = 32,
  parameter logic [N-1:0] WAKE_ALLOW = 32'h4000_000F,
  localparam int unsigned IDX_W      = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      src_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  offset_o,
  output logic              wake_o
);
  logic [N-1:0]     mask_q;
  logic [N-1:0]     src_pend;
  logic [N-1:0]     int_pend;
  logic [N-1:0]     wmask;
  logic [N-1:0]     src_clr;
  logic [N-1:0]     int_clr;
  logic             wake_we;
  logic [IDX_W-1:0] idx;

  assign src_clr = (we_i && addr_i == REG_SRC) ? wdata_i : '0;
  assign int_clr = (we_i && addr_i == REG_INT) ? wdata_i : '0;
  assign wake_we = we_i && addr_i == REG_WAKE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         mask_q <= '1;
    else if (we_i && addr_i == REG_MASK) mask_q <= wdata_i;
  end

  irq_src_pend #(.N(N)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .clr_i  (src_clr),
    .pend_o (src_pend)
  );

  irq_arbiter #(.N(N)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (src_pend),
    .mask_i (mask_q),
    .clr_i  (int_clr),
    .int_o  (int_pend),
    .idx_o  (idx)
  );

  irq_wake #(.N(N), .ALLOW(WAKE_ALLOW)) u_wake (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wake_we),
    .wdata_i (wdata_i),
    .pend_i  (src_pend),
    .wmask_o (wmask),
    .wake_o  (wake_o)
  );

  always_comb begin
    case (addr_i)
      REG_SRC:  rdata_o = src_pend;
      REG_MASK: rdata_o = mask_q;
      REG_INT:  rdata_o = int_pend;
      REG_OFF:  rdata_o = N'(idx);
      REG_WAKE: rdata_o = wmask;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o    = |int_pend;
  assign offset_o = idx;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int_pend[offset_o] && ((mask_q & int_pend) == '0 || $past(irq_o)))); // R7
endmodule

// File: tb/irq_pend_ctrl_bench.sv
`timescale 1ns/1ps
module irq_pend_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [4:0]  off;
  logic        wake;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_pend_ctrl u_irq_pend_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .offset_o(off), .wake_o(wake)
  );

  typedef struct packed {
    logic [31:0] mask;
    logic [31:0] pat;
    logic        irq;
    logic [4:0]  off;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'hFFFF_FFFE, 32'h0000_0001, 1'b1, 5'd0},   // R4 R5 index 0
    '{32'h0000_0000, 32'h8000_0000, 1'b1, 5'd31},  // R5 top index
    '{32'h0000_0000, 32'h0000_00A0, 1'b1, 5'd5},   // R5 lowest wins
    '{32'h0000_0030, 32'h0000_0130, 1'b1, 5'd8},   // R4 masked lower lose
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd8},   // R4 R7 all masked, offset held
    '{32'hFFFF_FFEF, 32'h0000_0010, 1'b1, 5'd4},   // R10 group summary 4
    '{32'hFFFF_FFDF, 32'h0000_0020, 1'b1, 5'd5},   // R10 group summary 5
    '{32'h0000_FFFF, 32'hFFFF_0000, 1'b1, 5'd16}   // R4 R5 upper half
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic pulse(input logic [31:0] p);
    @(negedge clk);
    src = p;
    @(negedge clk);
    src = '0;
  endtask

  task automatic clear_all();
    wr(3'd1, '1);
    wr(3'd0, '1);
    wr(3'd2, '1);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(3'd1, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R1 wake mask", d, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R1 src pend", d, 32'h0);
    rd(3'd2, d); chk("R1 int pend", d, 32'h0);
    chk("R1 irq/wake/off", {irq, wake, off}, 32'h0);
    rst_n = 1'b1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      clear_all();
      wr(3'd1, VECS[v].mask);
      pulse(VECS[v].pat);
      @(negedge clk);
      chk("R7 irq", {31'h0, irq}, {31'h0, VECS[v].irq});
      chk("R5 offset", {27'h0, off}, {27'h0, VECS[v].off});
      rd(3'd2, d);
      chk("R5 int pend one-hot", d, VECS[v].irq ? (32'h1 << VECS[v].off) : 32'h0);
      rd(3'd3, d);
      chk("R7 offset reg", d, {27'h0, VECS[v].off});
    end

    // R6 hold while occupied, reload after clear
    clear_all();
    wr(3'd1, 32'h0);
    pulse(32'h0000_0008);
    @(negedge clk);
    chk("R6 first load", {27'h0, off}, 32'd3);
    pulse(32'h0000_0002);
    @(negedge clk);
    chk("R6 held offset", {27'h0, off}, 32'd3);
    rd(3'd2, d); chk("R6 held int pend", d, 32'h0000_0008);
    rd(3'd0, d); chk("R2 both latched", d, 32'h0000_000A);
    wr(3'd2, 32'h0);
    rd(3'd2, d); chk("R3 int zero write", d, 32'h0000_0008);
    wr(3'd2, 32'h0000_0008);
    @(negedge clk);
    chk("R6 next winner", {27'h0, off}, 32'd1);
    chk("R7 irq again", {31'h0, irq}, 32'h1);

    // R2/R3 source-pending clear rules
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R2 src zero write", d, 32'h0000_000A);
    wr(3'd0, 32'h0000_0002);
    rd(3'd0, d); chk("R3 src clear", d, 32'h0000_0008);
    wr(3'd1, '1);
    @(negedge clk);
    src = 32'h0000_0040; we = 1'b1; addr = 3'd0; wdata = 32'h0000_0040;
    @(negedge clk);
    src = '0; we = 1'b0; wdata = '0;
    rd(3'd0, d); chk("R3 set beats clear", d & 32'h40, 32'h40);

    // R8/R9 wake mask
    clear_all();
    wr(3'd4, 32'h0);
    rd(3'd4, d); chk("R8 allow set only", d, 32'hBFFF_FFF0);
    chk("R9 idle no wake", {31'h0, wake}, 32'h0);
    pulse(32'h0000_0400);
    chk("R9 closed source", {31'h0, wake}, 32'h0);
    wr(3'd0, '1);
    pulse(32'h0000_0004);
    chk("R9 open source masked irq", {31'h0, wake}, 32'h1);
    chk("R9 irq stays low", {31'h0, irq}, 32'h0);
    wr(3'd4, '1);
    chk("R8 close again", {31'h0, wake}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule